// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block sits behind a serial receiver and moves the received octets into memory buffers. Each buffer is described by a descriptor in a small on-block descriptor RAM. The host reaches the same RAM through its own read/write port. Every descriptor takes four 16-bit words: status at offset 0, length at offset 1, buffer pointer at offset 2 and a spare word at offset 3. Descriptor `k` therefore starts at RAM word `4*k`.

The engine takes a descriptor when its empty flag is set and writes incoming octets to consecutive addresses starting at the buffer pointer. A buffer closes in one of two ways. It closes when the frame envelope (carrier detect) drops or a receive error ends the frame. It also closes when the buffer reaches the programmable maximum length, in which case the frame continues in the next descriptor. On closing, the engine writes status and length back in a single cycle and can raise a receive event. It then steps to the next descriptor, or back to descriptor 0 after one marked as the ring's end.

If the engine meets a descriptor that the host still holds, it discards the rest of the frame and raises a busy event. It resumes when the host hands the descriptor back. In continuous mode a descriptor that closes cleanly stays owned by the engine, so its buffer is refilled on the next pass round the ring.

Top module: `rxr_ring_engine`

## Requirements
- R1: After a synchronous active-low reset, no memory write is issued, both event bits and `irq` are 0, every descriptor word reads 0 and the engine points at descriptor 0.
- R2: An octet accepted while the current descriptor is owned (status bit 15 = 1) is written one cycle later to address pointer + offset, where the offset counts octets already placed in that buffer.
- R3: When the current descriptor has bit 15 = 0, arriving octets are dropped (no memory write) and event bit 1 (busy) is set. Once the host sets bit 15 again, the next frame is stored in it.
- R4: When carrier detect falls during a frame, the buffer closes in that cycle. The status gets last-flag bit 8 = 1 and bit 15 = 0 (unless R9 applies), the length word gets the frame's total octet count, and the engine moves on. First-flag bit 9 is set on the buffer that took the frame's first octet.
- R5: When a buffer's octet count reaches `max_len`, it closes with bit 8 = 0 and length = `max_len`, and the frame carries on in the next descriptor. Bit 9 is set there only if that buffer holds the frame's first octet.
- R6: After closing a descriptor whose wrap bit 14 = 1, the engine next uses descriptor 0.
- R7: Closing a descriptor with interrupt bit 13 = 1 sets event bit 0. `irq` is high when any event bit is 1 with its `evt_mask` bit = 1, and a 1 in `evt_clr` clears that event bit.
- R8: A nonzero `rx_err` during a frame ({DPLL error, carrier lost, overrun} onto status bits 2,1,0) closes the buffer with bit 8 = 1, copies the error bits, and always clears bit 15. The octet in the error cycle and the rest of the frame until carrier detect falls are not stored.
- R9: With continuous-mode bit 12 = 1, a close without error leaves bit 15 = 1.
- R10: A nonzero `rx_resid` in the cycle carrier detect falls sets non-aligned bit 4 in the closing status.
- R11: The written status keeps bits 14, 13 and 12 as the host set them and writes bits 11, 10, 7, 6, 5 and 3 as 0.
- R12: An octet presented while `rx_cd` = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | An octet is present on `rx_data` |
| rx_data | input | 8 | Received octet |
| rx_cd | input | 1 | Frame envelope (carrier detect) level |
| rx_err | input | 3 | {DPLL error, carrier lost, overrun} pulses |
| rx_resid | input | 3 | Leftover bit count, sampled when `rx_cd` falls |
| max_len | input | 16 | Maximum octets per buffer |
| host_we | input | 1 | Host write strobe for the descriptor RAM |
| host_addr | input | 5 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| evt_mask | input | 2 | Event enables for `irq` |
| evt_clr | input | 2 | Write-one-to-clear for events |
| evt | output | 2 | Events: bit 0 receive, bit 1 busy |
| irq | output | 1 | Interrupt request |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 16 | Buffer memory address |
| mem_data | output | 8 | Buffer memory write data |

## Verification
The bench sends one frame that spans three buffers. An engine that mishandled the full-buffer close would either lose the frame length or set the first flag on every buffer. Returning to a descriptor the host still holds shows whether the engine wraps: a design that ignored the wrap bit would go on writing into descriptor 4. An error arriving mid-frame under continuous mode must still hand the descriptor back and store none of the later octets. An octet offered with carrier low just before a frame would, if wrongly accepted, appear as the first octet in the buffer.

// File: rtl/rxr_pkg.sv
// Package: shared widths and status-word layout of the receive ring engine.
// Assumes 16-bit descriptor words and four words per descriptor.
package rxr_pkg;
    localparam int DW     = 16;
    localparam int ST_E   = 15;
    localparam int ST_W   = 14;
    localparam int ST_I   = 13;
    localparam int ST_CM  = 12;
    localparam int ST_F   = 9;
    localparam int ST_L   = 8;
    localparam int ST_NO  = 4;
    localparam logic [DW-1:0] RSV_MASK = 16'h0CE8;

    // Host-owned control bits of a descriptor, as the engine sees them.
    typedef struct packed {
        logic e;
        logic w;
        logic i;
        logic cm;
    } rxr_ctl_t;

    // Builds the status word written back on close; reserved bits stay zero.
    function automatic logic [DW-1:0] rxr_status(input logic e, input rxr_ctl_t c,
                                                 input logic f, input logic l,
                                                 input logic no, input logic [2:0] err);
        return {e, c.w, c.i, c.cm, 2'b00, f, l, 3'b000, no, 1'b0, err};
    endfunction
endpackage

// File: rtl/rxr_desc_ram.sv
// Descriptor RAM: host read/write port plus engine read of the current
// descriptor and a one-cycle engine write of status and length.
// Assumes the host does not write a descriptor the engine owns; on a clash
// the engine write wins.
module rxr_desc_ram
    import rxr_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC),
    localparam int AW = IW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    input  logic [IW-1:0]   eng_idx,
    output rxr_ctl_t        eng_ctl,
    output logic [DW-1:0]   eng_ptr,
    input  logic            eng_we,
    input  logic [DW-1:0]   eng_status,
    input  logic [DW-1:0]   eng_len
);
    logic [DW-1:0] words [NDESC*4];
    logic [DW-1:0] cur_st;

    // Storage update: reset, then host write, then engine write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NDESC*4; k++) words[k] <= '0;
        end else begin
            if (host_we) words[host_addr] <= host_wdata;
            if (eng_we) begin
                words[{eng_idx, 2'b00}] <= eng_status;
                words[{eng_idx, 2'b01}] <= eng_len;
            end
        end
    end

    // Combinational read paths for host and engine.
    always_comb begin
        host_rdata = words[host_addr];
        cur_st     = words[{eng_idx, 2'b00}];
        eng_ptr    = words[{eng_idx, 2'b10}];
        eng_ctl    = rxr_ctl_t'(cur_st[DW-1:DW-4]);
    end

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> ((eng_status & RSV_MASK) == '0));
endmodule

// File: rtl/rxr_evt.sv
// Event register: sticky receive and busy events, write-one-to-clear,
// masked interrupt request. Setting wins over clearing in the same cycle.
module rxr_evt (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_set,
    input  logic       busy_set,
    input  logic [1:0] evt_clr,
    input  logic [1:0] evt_mask,
    output logic [1:0] evt,
    output logic       irq
);
    // Event bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 2'b00;
        else        evt <= (evt & ~evt_clr) | {busy_set, rx_set};
    end

    // Interrupt request from enabled events.
    always_comb irq = |(evt & evt_mask);

    a_r7_rx_event_seen: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> evt[0]);
    a_r3_busy_event_seen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_set |=> evt[1]);
endmodule

// File: rtl/rxr_fill_ctrl.sv
// Fill controller: walks the descriptor ring, places octets into the current
// buffer, closes it on frame end, error or full length, and builds the
// write-back. Assumes one octet per cycle at most and a memory port with no stall.
module rxr_fill_ctrl
    import rxr_pkg::*;
#(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            rx_cd,
    input  logic [2:0]      rx_err,
    input  logic [2:0]      rx_resid,
    input  logic [DW-1:0]   max_len,
    input  rxr_ctl_t        cur_ctl,
    input  logic [DW-1:0]   cur_ptr,
    output logic [IW-1:0]   cur_idx,
    output logic            wb_we,
    output logic [DW-1:0]   wb_status,
    output logic [DW-1:0]   wb_len,
    output logic            mem_we,
    output logic [DW-1:0]   mem_addr,
    output logic [7:0]      mem_data,
    output logic            rx_set,
    output logic            busy_set
);
    logic [IW-1:0] cur_q;
    logic [DW-1:0] cnt_q, frm_q, cnt_nx;
    logic          in_frame_q, skip_q, first_q, cd_q;
    logic          byte_ok, acc, drop, cd_fall, ends, end_close, full_close, close, has_err;

    // Decode of this cycle's events.
    always_comb begin
        has_err    = (rx_err != 3'b000);
        byte_ok    = rx_valid && rx_cd && !skip_q && !has_err;
        acc        = byte_ok && cur_ctl.e;
        drop       = byte_ok && !cur_ctl.e;
        cd_fall    = cd_q && !rx_cd;
        ends       = in_frame_q && (cd_fall || has_err);
        end_close  = ends && cur_ctl.e;
        cnt_nx     = cnt_q + 16'd1;
        full_close = acc && (cnt_nx >= max_len);
        close      = full_close || end_close;
    end

    // Write-back word and event pulses for a closing buffer.
    always_comb begin
        wb_we     = close;
        wb_len    = end_close ? frm_q : cnt_nx;
        wb_status = rxr_status(cur_ctl.cm && !(end_close && has_err), cur_ctl,
                               full_close ? (first_q || !in_frame_q) : first_q,
                               end_close,
                               end_close && cd_fall && (rx_resid != 3'b000),
                               end_close ? rx_err : 3'b000);
        rx_set    = close && cur_ctl.i;
        busy_set  = drop;
        cur_idx   = cur_q;
    end

    // Ring position, fill counters and frame tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0; cnt_q <= '0; frm_q <= '0;
            in_frame_q <= 1'b0; skip_q <= 1'b0; first_q <= 1'b0; cd_q <= 1'b0;
            mem_we <= 1'b0; mem_addr <= '0; mem_data <= '0;
        end else begin
            cd_q   <= rx_cd;
            mem_we <= acc;
            if (acc) begin
                mem_addr <= cur_ptr + cnt_q;
                mem_data <= rx_data;
            end
            if (!rx_cd)                skip_q <= 1'b0;
            else if (drop || has_err)  skip_q <= 1'b1;
            if (acc) begin
                in_frame_q <= 1'b1;
                frm_q      <= frm_q + 16'd1;
            end else if (ends || drop) begin
                in_frame_q <= 1'b0;
                frm_q      <= '0;
            end
            if (close) begin
                cur_q   <= (cur_ctl.w || cur_q == IW'(NDESC-1)) ? '0 : cur_q + 1'b1;
                cnt_q   <= '0;
                first_q <= 1'b0;
            end else if (acc) begin
                cnt_q   <= cnt_nx;
                first_q <= first_q || !in_frame_q;
            end else if (ends) begin
                cnt_q   <= '0;
                first_q <= 1'b0;
            end
        end
    end

    a_r12_cd_low_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_cd |=> !mem_we);
    a_r3_unowned_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_ctl.e |=> !mem_we);
    a_r4_close_restarts_fill: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (cnt_q == '0));
    a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (close && cur_ctl.w) |=> (cur_q == '0));
    a_r8_error_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame_q && has_err) |=> !in_frame_q);
endmodule

// File: rtl/rxr_ring_engine.sv
// Top: receive descriptor ring engine. Connects the descriptor RAM, the
// fill controller and the event register.
module rxr_ring_engine #(
    parameter int NDESC = 8,
    localparam int IW = $clog2(NDESC),
    localparam int AW = IW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_cd,
    input  logic [2:0]    rx_err,
    input  logic [2:0]    rx_resid,
    input  logic [15:0]   max_len,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic [1:0]    evt_mask,
    input  logic [1:0]    evt_clr,
    output logic [1:0]    evt,
    output logic          irq,
    output logic          mem_we,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_data
);
    import rxr_pkg::*;

    logic [IW-1:0] cur_idx;
    rxr_ctl_t      cur_ctl;
    logic [DW-1:0] cur_ptr, wb_status, wb_len;
    logic          wb_we, rx_set, busy_set;

    rxr_desc_ram #(.NDESC(NDESC)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .eng_idx(cur_idx), .eng_ctl(cur_ctl), .eng_ptr(cur_ptr),
        .eng_we(wb_we), .eng_status(wb_status), .eng_len(wb_len)
    );

    rxr_fill_ctrl #(.NDESC(NDESC)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_cd(rx_cd),
        .rx_err(rx_err), .rx_resid(rx_resid), .max_len(max_len),
        .cur_ctl(cur_ctl), .cur_ptr(cur_ptr), .cur_idx(cur_idx),
        .wb_we(wb_we), .wb_status(wb_status), .wb_len(wb_len),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .rx_set(rx_set), .busy_set(busy_set)
    );

    rxr_evt u_evt (
        .clk(clk), .rst_n(rst_n),
        .rx_set(rx_set), .busy_set(busy_set),
        .evt_clr(evt_clr), .evt_mask(evt_mask),
        .evt(evt), .irq(irq)
    );
endmodule

// File: tb/rxr_ring_engine_bench.sv
// Bench: behavioural reference model compared every clock, plus directed
// read-back checks with hand-computed descriptor values.
module rxr_ring_engine_bench;
    localparam int ND = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        rx_valid = 0, rx_cd = 0;
    logic [7:0]  rx_data = 0;
    logic [2:0]  rx_err = 0, rx_resid = 0;
    logic [15:0] max_len = 16'd8;
    logic        host_we = 0;
    logic [4:0]  host_addr = 0;
    logic [15:0] host_wdata = 0, host_rdata;
    logic [1:0]  evt_mask = 2'b11, evt_clr = 2'b00, evt;
    logic        irq, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;

    int nchk = 0, nerr = 0;
    bit live = 0;
    logic [7:0]  wq_data[$];
    logic [15:0] wq_addr[$];

    always #5 clk = ~clk;

    rxr_ring_engine u_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_cd(rx_cd), .rx_err(rx_err), .rx_resid(rx_resid), .max_len(max_len),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_mask(evt_mask), .evt_clr(evt_clr),
        .evt(evt), .irq(irq), .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [15:0] md [ND*4];
    int  mcur, mcnt, mfrm;
    bit  min, mskip, mfirst, mcd, ewe;
    logic [15:0] eaddr;
    logic [7:0]  edata;
    logic [1:0]  mevt;

    always @(posedge clk) begin
        logic [15:0] st, ptr;
        bit own, ok, acc, drp, cdf, endf, ec, fc, er;
        if (!rst_n) begin
            for (int k = 0; k < ND*4; k++) md[k] = 0;
            mcur = 0; mcnt = 0; mfrm = 0; min = 0; mskip = 0; mfirst = 0; mcd = 0;
            ewe = 0; eaddr = 0; edata = 0; mevt = 0;
        end else begin
            st = md[mcur*4]; ptr = md[mcur*4+2]; own = st[15];
            er = (rx_err != 0);
            ok = rx_valid && rx_cd && !mskip && !er;
            acc = ok && own; drp = ok && !own;
            cdf = mcd && !rx_cd;
            endf = min && (cdf || er);
            ec = endf && own;
            fc = acc && (mcnt + 1 >= int'(max_len));
            mevt = (mevt & ~evt_clr) | {drp, (fc || ec) && st[13]};
            ewe = acc;
            if (acc) begin eaddr = ptr + 16'(mcnt); edata = rx_data; end
            if (host_we) md[host_addr] = host_wdata;
            if (fc || ec) begin
                md[mcur*4] = {st[12] && !(ec && er), st[14], st[13], st[12], 2'b00,
                              fc ? (mfirst || !min) : mfirst, ec, 3'b000,
                              ec && cdf && rx_resid != 0, 1'b0, ec ? rx_err : 3'b000};
                md[mcur*4+1] = ec ? 16'(mfrm) : 16'(mcnt + 1);
            end
            if (!rx_cd) mskip = 0; else if (drp || er) mskip = 1;
            if (acc) begin
                if (fc) begin mcnt = 0; mfirst = 0; end
                else begin mfirst = mfirst || !min; mcnt++; end
                min = 1; mfrm++;
            end else if (ec || endf || drp) begin
                min = 0; mfrm = 0;
                if (endf) begin mcnt = 0; mfirst = 0; end
            end
            if (fc || ec) mcur = (st[14] || mcur == ND-1) ? 0 : mcur + 1;
            mcd = rx_cd;
            #4;
            if (live) begin
                chk("R2 mem write strobe", mem_we, ewe);
                if (ewe) begin
                    chk("R2 mem address", mem_addr, eaddr);
                    chk("R2 mem data", mem_data, edata);
                end
                chk("R7 event bits", evt, mevt);
                chk("R7 irq", irq, |(mevt & evt_mask));
            end
            if (mem_we) begin wq_data.push_back(mem_data); wq_addr.push_back(mem_addr); end
        end
    end

    task automatic cyc(input bit v, input logic [7:0] d, input bit cd,
                       input logic [2:0] e, input logic [2:0] res);
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_cd = cd; rx_err = e; rx_resid = res;
        host_we = 0; evt_clr = 0;
    endtask

    task automatic hw(input int a, input logic [15:0] d);
        @(negedge clk);
        rx_valid = 0; rx_cd = 0; rx_err = 0; evt_clr = 0;
        host_we = 1; host_addr = 5'(a); host_wdata = d;
        @(negedge clk); host_we = 0;
    endtask

    task automatic hr(input int a, output logic [15:0] d);
        @(negedge clk);
        host_we = 0; host_addr = 5'(a);
        #1 d = host_rdata;
    endtask

    task automatic clr_evt();
        @(negedge clk); evt_clr = 2'b11; rx_valid = 0;
        @(negedge clk); evt_clr = 2'b00;
    endtask

    task automatic frame(input logic [7:0] base, input int n, input logic [2:0] res);
        for (int k = 0; k < n; k++) cyc(1, base + 8'(k), 1, 0, 0);
        cyc(0, 0, 0, 0, res);
        cyc(0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        #2000000;
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset mem_we", mem_we, 0);
        chk("R1 reset evt", evt, 0);
        chk("R1 reset irq", irq, 0);
        hr(0, r); chk("R1 reset descriptor word", r, 0);
        live = 1;
        for (int i = 0; i < 5; i++) hw(i*4+2, 16'h1000 + 16'(i) * 16'h0100);
        hw(0, 16'hA000); hw(4, 16'hA000); hw(8, 16'h8000); hw(12, 16'hE000); hw(16, 16'h8000);

        // Frame A: single buffer, closes on carrier drop.
        wq_data.delete(); wq_addr.delete();
        frame(8'h10, 5, 0);
        hr(0, r); chk("R4 close status F+L, handed back", r, 16'h2300);
        hr(1, r); chk("R4 frame length", r, 5);
        chk("R2 last address", wq_addr[$], 16'h1004);
        chk("R2 last data", wq_data[$], 8'h14);
        chk("R7 receive event", evt, 2'b01);
        clr_evt(); #1 chk("R7 cleared", evt, 2'b00);

        // Frame B: 10 octets over buffers of 4.
        max_len = 16'd4;
        frame(8'h20, 10, 0);
        hr(4, r);  chk("R5 full close first buffer", r, 16'h2200);
        hr(5, r);  chk("R5 full length", r, 4);
        hr(8, r);  chk("R5 middle buffer no F/L", r, 16'h0000);
        hr(13, r); chk("R4 total frame octets", r, 10);
        hr(12, r); chk("R4 last buffer keeps wrap", r, 16'h6100);
        clr_evt();

        // Frame C: back at descriptor 0, still held by the host.
        wq_data.delete();
        frame(8'h30, 3, 0);
        chk("R6 wrap, no write to descriptor 4", wq_data.size(), 0);
        chk("R3 busy event", evt, 2'b10);
        evt_mask = 2'b01; #1 chk("R7 masked busy", irq, 0);
        evt_mask = 2'b11;
        clr_evt();

        // Frame D: continuous mode, octet under low carrier, non-aligned end.
        max_len = 16'd8;
        hw(0, 16'hB000);
        wq_data.delete(); wq_addr.delete();
        cyc(1, 8'h77, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        frame(8'h40, 2, 3'd3);
        chk("R12 first stored octet", wq_data[0], 8'h40);
        chk("R3 resumes after host frees", wq_addr[0], 16'h1000);
        hr(0, r);
        chk("R9 empty bit kept", r[15], 1);
        chk("R10 non-aligned flag", r[4], 1);
        chk("R11 full status word", r, 16'hB310);
        hr(1, r); chk("R4 length in continuous mode", r, 2);
        clr_evt();

        // Frame E: overrun mid-frame on a continuous-mode descriptor.
        hw(4, 16'h9000);
        wq_data.delete();
        cyc(1, 8'h50, 1, 0, 0);
        cyc(1, 8'h51, 1, 0, 0);
        cyc(1, 8'h52, 1, 3'b001, 0);
        cyc(1, 8'h53, 1, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        hr(4, r); chk("R8 error close status", r, 16'h1301);
        hr(5, r); chk("R8 error length", r, 2);
        chk("R8 octets after error dropped", wq_data.size(), 2);
        chk("R7 no event without I bit", evt, 2'b00);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule